// File: doc/BRIEF.md
# Framebuffer Fetch Sequencer

This block issues the read requests that stream a frame out of memory into a display pixel FIFO. It holds two frame-buffer descriptors, each a byte start address and a byte end address (the address just past the last byte of the frame). It walks through one descriptor in bursts, then moves to the other one, and so alternates between them. Each request offers a word-aligned byte address and a burst length in 32-bit words. The request stays up until the memory side acknowledges it. A new request is raised only when the pixel FIFO reports more free space than a programmable level.

Software programs five registers through a simple write port. Writes land in shadow copies. The burst size, the FIFO level and both end addresses are loaded into the working set only when a frame starts, so a frame in flight keeps a consistent setup. A frame occupies `width * height * bits_per_pixel / 8` bytes. With 16, 24 or 32 bits per pixel and up to 2048 x 2048 pixels, the end address is the start plus that size. If both descriptors hold the same addresses, the block refetches a single frame over and over. When the last burst of a frame is acknowledged, the block emits a one-cycle end-of-frame pulse.

Top module: `fb_fetch_seq`

## Requirements
- R1: After reset, `reqValid` and `frameEnd` are low and no request is made until the enable bit is written to 1.
- R2: Register index 0 is the control word: bit 0 enable, bits [6:4] burst code, bits [10:8] FIFO level code. Index 1 is the buffer 0 start, 2 the buffer 0 end, 3 the buffer 1 start, 4 the buffer 1 end (byte addresses, word aligned, start below end).
- R3: Burst codes 0, 1, 2, 3 and 4 give 1, 2, 4, 8 and 16 words on `reqLen`. Codes 5, 6 and 7 give 16 words.
- R4: The first request of a frame uses the start address of its buffer. Each acknowledged request advances the address by `reqLen * 4` bytes.
- R5: A burst that would pass the end address is shortened so that it ends exactly at the end address.
- R6: `reqValid` rises only after a cycle in which `fifoFree` was strictly greater than the level code times 4.
- R7: Once raised, `reqValid`, `reqAddr` and `reqLen` hold steady until the cycle in which `reqAck` is high. `reqValid` then drops for at least one cycle.
- R8: `frameEnd` is high for exactly one cycle, the cycle after the acknowledge of a frame's last burst.
- R9: Frames alternate between buffer 0 and buffer 1. After an enable from idle, fetching starts with buffer 0. Identical descriptors make the same frame repeat.
- R10: Writes to the burst code, the FIFO level or either descriptor do not change the frame in progress. They take effect at the next frame start.
- R11: Writing the enable bit to 0 lets an outstanding request complete. No further request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regIdx | input | 3 | Register index for the write |
| regWrData | input | ADDR_W | Register write data |
| reqValid | output | 1 | Read request pending |
| reqAddr | output | ADDR_W | Byte address of the burst |
| reqLen | output | 5 | Burst length in 32-bit words (1 to 16) |
| reqAck | input | 1 | Memory side accepts the request |
| fifoFree | input | FREE_W | Free entries in the pixel FIFO |
| frameEnd | output | 1 | One-cycle pulse after a frame's last burst |

## Verification
The assertions check on every cycle the behaviour that is local in time. A request holds until it is acknowledged. A request rises only after a cycle with enough FIFO room. The burst length stays within 1 to 16 words. The end-of-frame pulse is one cycle wide and never overlaps a request. The address always moves forward inside a frame. The sequence of addresses needs the bench's scenarios: the truncation at the end address, the alternation between buffers, the delayed effect of shadowed writes, and the quiet state after a disable. For these the bench runs a reference model with random acknowledge gaps, random FIFO levels and register writes made mid-frame.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic startFrame;   // enable from idle: load working set, select buffer 0
    logic nextFrame;    // last burst accepted: load working set, step to next buffer
    logic advance;      // any burst accepted: move the address pointer
  } fbfStrobes_t;

  localparam int NUM_BUF   = 2;
  localparam int REG_IDX_W = 3;
  localparam int LEN_W     = 5;
  localparam int CODE_W    = 3;

  localparam logic [REG_IDX_W-1:0] IDX_CTRL = 3'd0;

  // Burst code to word count; codes above 4 saturate at 16 words
  function automatic logic [LEN_W-1:0] burstWords(input logic [CODE_W-1:0] code);
    logic [LEN_W-1:0] w;
    case (code)
      3'd0:    w = 5'd1;
      3'd1:    w = 5'd2;
      3'd2:    w = 5'd4;
      3'd3:    w = 5'd8;
      default: w = 5'd16;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/fbf_desc.sv
// One frame-buffer descriptor: shadow start/end plus working end address
module fbf_desc #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStart,
  input  logic              wrEnd,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              load,
  output logic [ADDR_W-1:0] shStart,
  output logic [ADDR_W-1:0] actEnd
);

  logic [ADDR_W-1:0] shEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shStart <= '0;
      shEnd   <= '0;
    end else begin
      if (wrStart) shStart <= wrData;
      if (wrEnd)   shEnd   <= wrData;
    end
  end

  // working copy is refreshed only at a frame boundary
  always_ff @(posedge clk) begin
    if (!rstN)     actEnd <= '0;
    else if (load) actEnd <= shEnd;
  end

endmodule

// File: rtl/fbf_dpath.sv
module fbf_dpath
  import fbf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int FREE_W    = 8,
  parameter int THR_SHIFT = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_IDX_W-1:0] regIdx,
  input  logic [ADDR_W-1:0]    regWrData,
  input  fbfStrobes_t          strb,
  input  logic [FREE_W-1:0]    fifoFree,
  output logic                 enable,
  output logic                 roomOk,
  output logic                 lastBurst,
  output logic [ADDR_W-1:0]    reqAddr,
  output logic [LEN_W-1:0]     reqLen
);

  localparam int BUF_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
  localparam int LVL_W = CODE_W + THR_SHIFT;
  localparam int CMP_W = (FREE_W > LVL_W) ? FREE_W : LVL_W;

  logic [CODE_W-1:0] shCode, shThr, actCode, actThr;
  logic [ADDR_W-1:0] shStartArr [NUM_BUF];
  logic [ADDR_W-1:0] actEndArr  [NUM_BUF];
  logic [BUF_W-1:0]  bufSel, bufNext;
  logic [ADDR_W-1:0] curAddr;
  logic              loadSet;

  assign loadSet = strb.startFrame | strb.nextFrame;

  // control word shadow; enable acts at once, the fields wait for a frame start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable <= 1'b0;
      shCode <= '0;
      shThr  <= '0;
    end else if (regWrEn && regIdx == IDX_CTRL) begin
      enable <= regWrData[0];
      shCode <= regWrData[6:4];
      shThr  <= regWrData[10:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actCode <= '0;
      actThr  <= '0;
    end else if (loadSet) begin
      actCode <= shCode;
      actThr  <= shThr;
    end
  end

  // descriptors: buffer b lives at indices 1+2b (start) and 2+2b (end)
  for (genvar b = 0; b < NUM_BUF; b++) begin : gDesc
    fbf_desc #(.ADDR_W(ADDR_W)) uDesc (
      .clk     (clk),
      .rstN    (rstN),
      .wrStart (regWrEn && regIdx == REG_IDX_W'(1 + 2*b)),
      .wrEnd   (regWrEn && regIdx == REG_IDX_W'(2 + 2*b)),
      .wrData  (regWrData),
      .load    (loadSet),
      .shStart (shStartArr[b]),
      .actEnd  (actEndArr[b])
    );
  end

  assign bufNext = (bufSel == BUF_W'(NUM_BUF - 1)) ? '0 : bufSel + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufSel  <= '0;
      curAddr <= '0;
    end else if (strb.startFrame) begin
      bufSel  <= '0;
      curAddr <= shStartArr[0];
    end else if (strb.nextFrame) begin
      bufSel  <= bufNext;
      curAddr <= shStartArr[bufNext];
    end else if (strb.advance) begin
      curAddr <= curAddr + ADDR_W'({reqLen, 2'b00});
    end
  end

  // burst length: programmed size, cut short at the end address
  logic [ADDR_W-1:0] bytesLeft, burstBytes;
  logic [LEN_W-1:0]  burstW;
  logic              shortBurst;

  assign burstW     = burstWords(actCode);
  assign burstBytes = ADDR_W'({burstW, 2'b00});
  assign bytesLeft  = actEndArr[bufSel] - curAddr;
  assign shortBurst = bytesLeft < burstBytes;
  assign reqLen     = shortBurst ? bytesLeft[LEN_W+1:2] : burstW;
  assign lastBurst  = bytesLeft <= burstBytes;
  assign reqAddr    = curAddr;

  // FIFO room: free level must exceed the level code scaled by 2^THR_SHIFT
  logic [LVL_W-1:0] level;
  assign level  = LVL_W'(actThr) << THR_SHIFT;
  assign roomOk = CMP_W'(fifoFree) > CMP_W'(level);

  AST_ADDR_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance && !strb.nextFrame |=> curAddr > $past(curAddr)); // R4

endmodule

// File: rtl/fbf_ctrl.sv
module fbf_ctrl
  import fbf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        roomOk,
  input  logic        lastBurst,
  input  logic        reqAck,
  output fbfStrobes_t strb,
  output logic        reqValid,
  output logic        frameEnd
);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_REQ} fetchState_t;

  fetchState_t state, stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (enable) begin
          strb.startFrame = 1'b1;
          stateNext       = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!enable)     stateNext = ST_IDLE;
        else if (roomOk) stateNext = ST_REQ;
      end
      ST_REQ: begin
        if (reqAck) begin
          strb.advance   = 1'b1;
          strb.nextFrame = lastBurst;
          stateNext      = enable ? ST_WAIT : ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      frameEnd <= 1'b0;
    end else begin
      state    <= stateNext;
      frameEnd <= (state == ST_REQ) && reqAck && lastBurst;
    end
  end

  assign reqValid = (state == ST_REQ);

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqAck |=> reqValid); // R7
  AST_ROOM_BEFORE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> $past(roomOk)); // R6
  AST_EOF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> !frameEnd); // R8
  AST_EOF_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> !reqValid); // R8

endmodule

// File: rtl/fb_fetch_seq.sv
module fb_fetch_seq
  import fbf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int FREE_W    = 8,
  parameter int THR_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regIdx,
  input  logic [ADDR_W-1:0] regWrData,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [4:0]        reqLen,
  input  logic              reqAck,
  input  logic [FREE_W-1:0] fifoFree,
  output logic              frameEnd
);

  fbfStrobes_t strb;
  logic        enable, roomOk, lastBurst;

  fbf_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .roomOk    (roomOk),
    .lastBurst (lastBurst),
    .reqAck    (reqAck),
    .strb      (strb),
    .reqValid  (reqValid),
    .frameEnd  (frameEnd)
  );

  fbf_dpath #(
    .ADDR_W    (ADDR_W),
    .FREE_W    (FREE_W),
    .THR_SHIFT (THR_SHIFT)
  ) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regIdx    (regIdx),
    .regWrData (regWrData),
    .strb      (strb),
    .fifoFree  (fifoFree),
    .enable    (enable),
    .roomOk    (roomOk),
    .lastBurst (lastBurst),
    .reqAddr   (reqAddr),
    .reqLen    (reqLen)
  );

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqLen >= 5'd1 && reqLen <= 5'd16)); // R3

endmodule

// File: tb/tb_fb_fetch_seq.sv
module tb_fb_fetch_seq;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [2:0]  regIdx;
  logic [31:0] regWrData;
  logic        reqValid;
  logic [31:0] reqAddr;
  logic [4:0]  reqLen;
  logic        reqAck;
  logic [7:0]  fifoFree;
  logic        frameEnd;

  always #4 clk = ~clk;  // 125 MHz

  fb_fetch_seq dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regIdx(regIdx),
    .regWrData(regWrData), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqAck(reqAck), .fifoFree(fifoFree), .frameEnd(frameEnd)
  );

  int checks = 0;
  int errors = 0;

  // reference model: shadow and working copies
  logic        mShEn;
  logic [2:0]  mShCode, mShThr, mCode, mThr;
  logic [31:0] mShStart [2];
  logic [31:0] mShEnd   [2];
  logic [31:0] mEnd     [2];
  logic [31:0] mAddr;
  int          mBuf;
  logic        mEofExp, prevValid, prevAck, quietChk;
  logic [7:0]  prevFree;
  int          ackPct, lowFreePct;
  logic        wrPend;
  logic [2:0]  wrIdx;
  logic [31:0] wrData;

  function automatic logic [4:0] burstOf(input logic [2:0] code);
    return (code >= 3'd4) ? 5'd16 : 5'(1 << code);
  endfunction

  function automatic logic [4:0] expLen(input logic [31:0] addr, input logic [31:0] e,
                                         input logic [2:0] code);
    logic [31:0] words;
    words = (e - addr) >> 2;
    return (words < 32'(burstOf(code))) ? words[4:0] : burstOf(code);
  endfunction

  function automatic logic [31:0] frameBytes(input int w, input int h, input int bpp);
    return 32'((w * h * bpp) / 8);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic loadModel();
    mCode = mShCode;
    mThr  = mShThr;
    for (int b = 0; b < 2; b++) mEnd[b] = mShEnd[b];
  endtask

  // one cycle: sample at the falling edge, compare, then drive the next inputs
  task automatic step();
    logic doAck;
    @(negedge clk);
    check("R8 frameEnd", 32'(frameEnd), 32'(mEofExp));
    mEofExp = 1'b0;
    if (quietChk) check("R11 no request after disable", 32'(reqValid), 32'd0);
    if (reqValid) begin
      if (!prevValid)
        check("R6 room before request", 32'(prevFree > ({5'd0, mThr} << 2)), 32'd1);
      check((prevValid && !prevAck) ? "R7 address held" : "R4/R9/R10 address",
            reqAddr, mAddr);
      check("R2/R3/R5/R10 length", 32'(reqLen), 32'(expLen(mAddr, mEnd[mBuf], mCode)));
    end
    doAck = reqValid && ($urandom_range(99) < ackPct);
    if (doAck) begin
      logic [4:0] l;
      l = expLen(mAddr, mEnd[mBuf], mCode);
      if (mAddr + 32'({l, 2'b00}) == mEnd[mBuf]) begin
        mEofExp = 1'b1;
        mBuf    = 1 - mBuf;
        loadModel();
        mAddr   = mShStart[mBuf];
      end else begin
        mAddr = mAddr + 32'({l, 2'b00});
      end
    end
    regWrEn = wrPend;
    regIdx  = wrIdx;
    regWrData = wrData;
    if (wrPend) begin
      // R2: index 0 control, 1/2 buffer 0 start/end, 3/4 buffer 1 start/end
      case (wrIdx)
        3'd0: begin
          if (wrData[0] && !mShEn) begin
            mShCode = wrData[6:4]; mShThr = wrData[10:8];
            loadModel();
            mBuf = 0; mAddr = mShStart[0];
          end
          mShEn = wrData[0]; mShCode = wrData[6:4]; mShThr = wrData[10:8];
        end
        3'd1: mShStart[0] = wrData;
        3'd2: mShEnd[0]   = wrData;
        3'd3: mShStart[1] = wrData;
        3'd4: mShEnd[1]   = wrData;
        default: ;
      endcase
    end
    wrPend    = 1'b0;
    prevValid = reqValid;
    prevAck   = doAck;
    reqAck    = doAck;
    fifoFree  = ($urandom_range(99) < lowFreePct) ? 8'($urandom_range(0, 31))
                                                  : 8'($urandom_range(32, 255));
    prevFree  = fifoFree;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic regWrite(input logic [2:0] idx, input logic [31:0] d);
    wrPend = 1'b1; wrIdx = idx; wrData = d;
    step();
  endtask

  function automatic logic [31:0] ctrlWord(input logic en, input logic [2:0] code,
                                           input logic [2:0] thr);
    return {21'd0, thr, 1'b0, code, 3'd0, en};
  endfunction

  initial begin
    void'($urandom(32'd20240607));
    rstN = 1'b0; regWrEn = 1'b0; regIdx = '0; regWrData = '0; reqAck = 1'b0;
    fifoFree = 8'd255; prevFree = 8'd255;
    mShEn = 1'b0; mShCode = '0; mShThr = '0; mCode = '0; mThr = '0;
    for (int b = 0; b < 2; b++) begin mShStart[b] = '0; mShEnd[b] = '0; mEnd[b] = '0; end
    mAddr = '0; mBuf = 0; mEofExp = 1'b0; prevValid = 1'b0; prevAck = 1'b0;
    quietChk = 1'b0; ackPct = 100; lowFreePct = 0; wrPend = 1'b0; wrIdx = '0; wrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reqValid in reset", 32'(reqValid), 32'd0);
    check("R1 frameEnd in reset", 32'(frameEnd), 32'd0);
    rstN = 1'b1;
    quietChk = 1'b1;
    run(10);                          // R1: nothing before enable
    quietChk = 1'b0;

    // directed: truncated bursts, two different frames (R5, R9)
    regWrite(3'd1, 32'h100);
    regWrite(3'd2, 32'h100 + frameBytes(4, 3, 24));   // 9 words: 8 then 1
    regWrite(3'd3, 32'h800);
    regWrite(3'd4, 32'h800 + frameBytes(2, 2, 32));   // 4 words with burst 8
    regWrite(3'd0, ctrlWord(1'b1, 3'd3, 3'd2));
    run(200);

    // directed: identical descriptors repeat one frame (R9), saturating code (R3)
    regWrite(3'd3, 32'h100);
    regWrite(3'd4, 32'h100 + frameBytes(8, 2, 16));
    regWrite(3'd2, 32'h100 + frameBytes(8, 2, 16));
    regWrite(3'd0, ctrlWord(1'b1, 3'd6, 3'd7));
    lowFreePct = 50;
    run(300);

    // random: mid-frame writes, random acks and FIFO levels (R10)
    for (int r = 0; r < 60; r++) begin
      int b;
      b = $urandom_range(1);
      ackPct = $urandom_range(30, 100);
      lowFreePct = $urandom_range(0, 60);
      regWrite(3'(1 + 2*b), 32'h1000 + 32'(4 * $urandom_range(0, 63)));
      regWrite(3'(2 + 2*b), 32'h1100 + 32'(4 * $urandom_range(0, 15)));
      regWrite(3'd0, ctrlWord(1'b1, 3'($urandom_range(7)), 3'($urandom_range(7))));
      run($urandom_range(60, 200));
    end

    // disable: outstanding request completes, then silence (R11)
    ackPct = 100;
    lowFreePct = 0;
    regWrite(3'd0, ctrlWord(1'b0, 3'd2, 3'd0));
    run(20);
    quietChk = 1'b1;
    run(40);
    quietChk = 1'b0;

    // re-enable from idle starts again at buffer 0 (R9)
    regWrite(3'd1, 32'h2000);
    regWrite(3'd2, 32'h2040);
    regWrite(3'd3, 32'h3000);
    regWrite(3'd4, 32'h3010);
    regWrite(3'd0, ctrlWord(1'b1, 3'd1, 3'd1));
    run(300);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule